// File: doc/BRIEF.md
# Valid-Qualified Bus Clock Crossing

This block carries a multi-bit word from a slow source clock domain into a faster destination clock domain. Only a one-bit launch flag is synchronized. The word itself crosses without synchronization. A source pulse loads the word into a source holding register and flips the launch flag. The holding register then keeps the word steady while the flag travels through a two-flop synchronizer in the destination domain.

In the destination domain, the capture state machine compares the newest synchronized flag sample with the previous one. When they differ, it raises a one-cycle capture enable. That enable loads the word, which has settled by then, into the output register. The enable is generated in the destination domain, so the clock enable of every destination data flop comes from destination logic.

The state machine has two states. In `DST_IDLE` it holds the output and drives no valid. The transition *capture* (enable high) leads to `DST_SHOW`, where `dst_valid_o` is high for exactly one cycle. The transition *settle* (enable low) returns from `DST_SHOW` to `DST_IDLE`. The transition *recapture* (enable high again) stays in `DST_SHOW`; it is included for completeness only. The source side has no state machine; it is just the holding register and the flag.

The sender must respect a minimum spacing. Words must be at least two source cycles apart, and the source period must be at least three destination periods. Closer spacing is not supported.

Top module: `vbus_xfer`

## Requirements
- R1: After reset of each domain, `dst_valid_o` is 0, `dst_data_o` is all zeros, and the source holding register and launch flag are 0.
- R2: Each source cycle with `src_valid_i` high loads `src_data_i` into the source holding register and inverts the launch flag. In every other source cycle both keep their values.
- R3: Changes on `src_data_i` while `src_valid_i` is low have no effect: `dst_valid_o` stays low and `dst_data_o` keeps its value.
- R4: The launch flag passes through exactly two destination flops, with no logic before or between them. The data word takes no synchronizer and reaches only the destination data register.
- R5: A difference between the last two synchronized flag samples produces a capture enable lasting one destination cycle. The destination data register loads only on that enable.
- R6: `dst_valid_o` is a single-cycle pulse that rises at the clock edge where the word is captured. During that cycle `dst_data_o` shows the captured word, and it holds that value until the next capture.
- R7: Every launched word appears on `dst_data_o` exactly once and in launch order. Its pulse comes no more than 6 destination rising edges after the source cycle in which it was driven.
- R8: Two consecutive identical words give two separate output pulses, because detection follows the flag and not the data.
- R9: Words sent at the minimum spacing are all delivered correctly: two source cycles apart, with the source period three times the destination period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_valid_i | input | 1 | One source cycle per word to launch |
| src_data_i | input | DATA_W | Word to launch, sampled when `src_valid_i` is high |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid_o | output | 1 | One-cycle pulse marking a newly captured word |
| dst_data_o | output | DATA_W | Captured word, held between pulses |

## Verification
Each kind of wrong internal state shows up at the ports within a few destination cycles.

- **Wrong synchronizer or edge detector.** A lost or duplicated flag edge appears as a missing pulse, an extra pulse, or a pulse later than the 6-edge latency bound.
- **Capture enable not confined to the edge.** If the data register loads outside the enable, `dst_data_o` changes between pulses. That is visible on the first destination clock where it happens.
- **Source register loading without a pulse.** The next pulse delivers a word that does not match the expected word.

The bench compares against its queue model on every destination clock. Its sequences include repeated words, minimum spacing and data churn while `src_valid_i` is low.

// File: rtl/vbx_pkg.sv
package vbx_pkg;

    // Destination capture state machine
    typedef enum logic [0:0] {
        DST_IDLE = 1'b0,
        DST_SHOW = 1'b1
    } dst_state_e;

endpackage

// File: rtl/vbx_src_launch.sv
module vbx_src_launch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              flag_o
);

    logic [DATA_W-1:0] hold_q;
    logic              flag_q;

    // Holding register: loads only on a launch pulse, otherwise keeps the word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (valid_i) begin
            hold_q <= data_i;
        end
    end

    // Launch flag: flips once per accepted word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (valid_i) begin
            flag_q <= ~flag_q;
        end
    end

    assign hold_o = hold_q;
    assign flag_o = flag_q;

    // R2: no pulse, no change to the held word
    a_r2_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(hold_o));

    // R2: a pulse flips the flag
    a_r2_flag_flips: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (flag_o != $past(flag_o)));

    // R2: a pulse captures the input word
    a_r2_word_taken: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (hold_o == $past(data_i)));

endmodule

// File: rtl/vbx_sync.sv
module vbx_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    localparam int LAST = DEPTH - 1;

    // Plain flop chain: nothing between stages
    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], d_i};
        end
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/vbx_dst_capture.sv
module vbx_dst_capture
    import vbx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    dst_state_e        state_q, state_d;
    logic              seen_q;
    logic              cap_en;
    logic [DATA_W-1:0] data_q;

    // Previous synchronized flag sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= flag_i;
        end
    end

    assign cap_en = flag_i ^ seen_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DST_IDLE: if (cap_en) state_d = DST_SHOW;              // capture
            DST_SHOW: state_d = cap_en ? DST_SHOW : DST_IDLE;      // recapture / settle
            default:  state_d = DST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Destination data register, clock-enabled from this domain only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= bus_i;
        end
    end

    // Outputs
    always_comb begin
        data_o  = data_q;
        valid_o = 1'b0;
        unique case (state_q)
            DST_IDLE: valid_o = 1'b0;
            DST_SHOW: valid_o = 1'b1;
            default:  valid_o = 1'b0;
        endcase
    end

    // R5: the data register moves only on the capture enable
    a_r5_load_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(data_o));

    // R6: a capture is announced in the following cycle
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> valid_o);

    // R6: the valid pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: the capture enable never lasts two cycles
    a_r5_enable_single: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !cap_en);

endmodule

// File: rtl/vbus_xfer.sv
module vbus_xfer #(
    parameter int DATA_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid_o,
    output logic [DATA_W-1:0] dst_data_o
);

    logic [DATA_W-1:0] hold_bus;
    logic              launch_flag;
    logic              flag_sync;

    vbx_src_launch #(.DATA_W(DATA_W)) u_launch (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .valid_i (src_valid_i),
        .data_i  (src_data_i),
        .hold_o  (hold_bus),
        .flag_o  (launch_flag)
    );

    // R4: only the flag is synchronized
    vbx_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_i   (launch_flag),
        .q_o   (flag_sync)
    );

    vbx_dst_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .flag_i  (flag_sync),
        .bus_i   (hold_bus),
        .data_o  (dst_data_o),
        .valid_o (dst_valid_o)
    );

endmodule

// File: tb/tb_vbus_xfer.sv
module tb_vbus_xfer;

    localparam int W       = 16;
    localparam int LAT_MAX = 6;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         src_valid_i = 1'b0;
    logic [W-1:0] src_data_i = '0;
    logic         dst_valid_o;
    logic [W-1:0] dst_data_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // 125 MHz destination clock, 3 ns phase offset; source period three times longer
    initial begin
        #3;
        forever #4 dst_clk = ~dst_clk;
    end
    always #12 src_clk = ~src_clk;

    vbus_xfer #(.DATA_W(W)) dut (
        .src_clk     (src_clk),
        .src_rst_n   (src_rst_n),
        .src_valid_i (src_valid_i),
        .src_data_i  (src_data_i),
        .dst_clk     (dst_clk),
        .dst_rst_n   (dst_rst_n),
        .dst_valid_o (dst_valid_o),
        .dst_data_o  (dst_data_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: queue of launched words and their launch times
    logic [W-1:0] exp_q[$];
    int           t_q[$];
    int           dst_edges = 0;
    logic [W-1:0] last_word = '0;
    bit           prev_valid = 1'b0;
    bit           model_on = 1'b0;

    always @(posedge dst_clk) dst_edges++;

    // Compare every destination cycle, away from the active edge
    always @(negedge dst_clk) begin
        if (model_on) begin
            if (dst_valid_o) begin
                check(!prev_valid, "R6 pulse one cycle", 1, 0);
                check(exp_q.size() > 0, "R7 pulse with nothing launched", 1, 0);
                if (exp_q.size() > 0) begin
                    check(dst_data_o == exp_q[0], "R7 order/value", dst_data_o, exp_q[0]);
                    check(dst_edges - t_q[0] <= LAT_MAX, "R7 latency", dst_edges - t_q[0], LAT_MAX);
                    void'(exp_q.pop_front());
                    void'(t_q.pop_front());
                end
                last_word = dst_data_o;
            end else begin
                check(dst_data_o == last_word, "R6 data held between pulses", dst_data_o, last_word);
                if (exp_q.size() > 0)
                    check(dst_edges - t_q[0] <= LAT_MAX, "R7 word overdue", dst_edges - t_q[0], LAT_MAX);
            end
            prev_valid = dst_valid_o;
        end
    end

    task automatic send(input logic [W-1:0] w, input int gap);
        @(negedge src_clk);
        src_valid_i = 1'b1;
        src_data_i  = w;
        exp_q.push_back(w);
        t_q.push_back(dst_edges);
        @(negedge src_clk);
        src_valid_i = 1'b0;
        for (int i = 1; i < gap; i++) @(negedge src_clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) @(negedge dst_clk);
        check(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge src_clk);
        check(dst_valid_o == 1'b0, "R1 reset valid", dst_valid_o, 0);
        check(dst_data_o == '0, "R1 reset data", dst_data_o, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (2) @(negedge src_clk);
        check(dst_valid_o == 1'b0, "R1 idle after reset", dst_valid_o, 0);
        model_on = 1'b1;

        // R2 / R7: basic words with generous gaps
        send(16'hA5A5, 4);
        send(16'h0001, 4);
        send(16'hFFFF, 4);
        send(16'h0000, 4);
        drain();
        check(last_word == 16'h0000, "R2 last word", last_word, 16'h0000);

        // R8: identical consecutive words give separate pulses
        send(16'h1234, 3);
        send(16'h1234, 3);
        send(16'h1234, 3);
        drain();
        check(last_word == 16'h1234, "R8 repeated word", last_word, 16'h1234);

        // R3: data churn without src_valid_i has no effect
        for (int i = 0; i < 8; i++) begin
            @(negedge src_clk);
            src_data_i = W'(16'h5000 + i * 16'h0111);
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge dst_clk);
            check(dst_valid_o == 1'b0, "R3 no pulse without launch", dst_valid_o, 0);
            check(dst_data_o == 16'h1234, "R3 output unchanged", dst_data_o, 16'h1234);
        end

        // R9: minimum spacing, walking-one and alternating patterns
        for (int i = 0; i < W; i++) send(W'(1) << i, 2);
        send(16'h5555, 2);
        send(16'hAAAA, 2);
        drain();
        check(last_word == 16'hAAAA, "R9 min spacing final word", last_word, 16'hAAAA);

        // R4 / R5: mixed gaps and pseudo-random words
        for (int i = 0; i < 40; i++) send(W'($urandom), 2 + int'($urandom_range(0, 3)));
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule